// File: doc/BRIEF.md
# CPU and Blitter Memory Slot Arbiter

This block decides, for every memory bus slot, whether the CPU or the blitter DMA engine drives the bus. Slots already owned by bitplane fetch or another DMA channel are flagged on an input and are never granted to either requester. The block also keeps the blitter's done and zero-result flags, forms the busy and zero bits of a status word, and raises an interrupt request bit a fixed number of cycles after a blit completes.

The blitter normally takes every free slot while a blit is active. When blitter priority is off, a counter tracks how many slots the CPU has been waiting. Once that wait reaches four, the CPU takes the next free slot even if the blitter wants it. When blitter priority is on, the CPU waits until the blitter no longer needs the bus. Each clock cycle is one slot, and grants are combinational in the slot they apply to.

Top module: `cpu_blit_arbiter`

## Requirements
- R1: At most one of `cpu_gnt_o` and `blt_gnt_o` is high in a slot, and neither is high while `slot_taken_i` is high.
- R2: With priority off and the blitter active and requesting in every slot, a CPU request that starts in slot k is granted in slot k+3. This is the slot in which its wait count reaches 4.
- R3: Slots flagged as taken still add to the CPU wait count. A CPU that waited through taken slots is granted at the first free slot once its count has reached 4, ahead of the blitter.
- R4: With `blt_pri_i` high, the CPU is never granted a slot that the active blitter requests.
- R5: The blitter is granted a free slot it requests while a blit is active, unless the CPU takes that slot. Once the done flag is set, the blitter is never granted.
- R6: A CPU request is granted in its first free slot when the active blitter is not requesting that slot.
- R7: The wait count restarts after each CPU grant. A CPU request held continuously against a requesting blitter with priority off is granted every fourth slot.
- R8: `status_o` bit 14 is blitter busy and bit 13 is the zero-result flag; all other status bits read 0. After reset, busy reads 0.
- R9: With `legacy_busy_i` high, busy reads 1 only from the slot after the blitter's first grant in the current blit. With it low, busy reads 1 from the slot after the start.
- R10: `blt_done_i` during an active blit sets the done flag, so busy reads 0 from the next slot. It also latches `blt_zero_i` into the zero flag. `irq_o` bit 6 is high for exactly one slot, four slots after the done slot; all other `irq_o` bits stay 0.
- R11: `blt_start_i` clears the done flag, the zero flag and the got-grant flag from the next slot. Start wins over a simultaneous done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU wants the bus, held until granted |
| blt_req_i | input | 1 | Blitter wants this slot |
| blt_pri_i | input | 1 | Blitter priority: CPU never steals |
| slot_taken_i | input | 1 | Slot owned by bitplane or other DMA |
| blt_start_i | input | 1 | A new blit begins |
| blt_done_i | input | 1 | The current blit finishes |
| blt_zero_i | input | 1 | Zero result of the finishing blit |
| legacy_busy_i | input | 1 | Busy shown only after the first blitter grant |
| cpu_gnt_o | output | 1 | Slot granted to the CPU |
| blt_gnt_o | output | 1 | Slot granted to the blitter |
| status_o | output | 16 | Status word: bit 14 busy, bit 13 zero |
| irq_o | output | 16 | Interrupt request set pulses, bit 6 blit done |

## Verification
Grants are due in the same slot as the request inputs that cause them. Busy and zero change one slot after the edge that samples a start, a done or a first grant, and the interrupt pulse appears four slots after the done slot. The driver applies each slot's inputs just after a rising edge and queues that slot's expected outputs from the state accumulated so far. The monitor compares them at the falling edge of the same slot, so every register stage is already counted when the sample is taken.

// File: rtl/cba_pkg.sv
package cba_pkg;
  localparam int unsigned STAT_W = 16;

  typedef struct packed {
    logic cpu;
    logic blt;
  } gnt_t;
endpackage

// File: rtl/cba_wait_ctr.sv
module cba_wait_ctr #(
  parameter int unsigned STEAL_WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic cpu_gnt_i,
  output logic steal_ok_o
);
  localparam int unsigned CNT_W = $clog2(STEAL_WAIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STEAL_WAIT);

  logic [CNT_W-1:0] cnt_q, eff;
  logic             pend_q;

  // a fresh access counts as its first waited slot
  assign eff        = pend_q ? cnt_q : CNT_W'(1);
  assign steal_ok_o = (eff >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (!cpu_req_i || cpu_gnt_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= 1'b1;
      cnt_q  <= (eff >= LIMIT) ? LIMIT : eff + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cba_slot_grant.sv
module cba_slot_grant
  import cba_pkg::*;
(
  input  logic cpu_req_i,
  input  logic blt_req_i,
  input  logic blt_active_i,
  input  logic blt_pri_i,
  input  logic slot_taken_i,
  input  logic steal_ok_i,
  output gnt_t gnt_o
);
  logic free, blt_want, cpu_wins;

  assign free     = !slot_taken_i;
  assign blt_want = blt_req_i && blt_active_i;
  assign cpu_wins = !blt_want || (!blt_pri_i && steal_ok_i);

  always_comb begin
    gnt_o     = '0;
    gnt_o.cpu = free && cpu_req_i && cpu_wins;
    gnt_o.blt = free && blt_want && !gnt_o.cpu;
  end
endmodule

// File: rtl/cba_blit_status.sv
module cba_blit_status
  import cba_pkg::*;
#(
  parameter int unsigned IRQ_DELAY = 4,
  parameter int unsigned BUSY_BIT  = 14,
  parameter int unsigned ZERO_BIT  = 13,
  parameter int unsigned IRQ_BIT   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              zero_i,
  input  logic              legacy_i,
  input  logic              blt_gnt_i,
  output logic              active_o,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] irq_o
);
  logic done_q, zero_q, got_q, evt, irq_bit;

  assign evt      = done_i && !done_q && !start_i;
  assign active_o = !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      zero_q <= 1'b0;
      got_q  <= 1'b0;
    end else if (start_i) begin
      done_q <= 1'b0;
      zero_q <= 1'b0;
      got_q  <= 1'b0;
    end else begin
      if (evt) begin
        done_q <= 1'b1;
        zero_q <= zero_i;
      end
      if (blt_gnt_i) got_q <= 1'b1;
    end
  end

  generate
    if (IRQ_DELAY <= 1) begin : g_dly1
      logic dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= 1'b0;
        else         dly_q <= evt;
      end
      assign irq_bit = dly_q;
    end else begin : g_dlyn
      logic [IRQ_DELAY-1:0] dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dly_q <= '0;
        else         dly_q <= {dly_q[IRQ_DELAY-2:0], evt};
      end
      assign irq_bit = dly_q[IRQ_DELAY-1];
    end
  endgenerate

  always_comb begin
    status_o           = '0;
    status_o[BUSY_BIT] = !done_q && (!legacy_i || got_q);
    status_o[ZERO_BIT] = zero_q;
    irq_o              = '0;
    irq_o[IRQ_BIT]     = irq_bit;
  end
endmodule

// File: rtl/cpu_blit_arbiter.sv
module cpu_blit_arbiter
  import cba_pkg::*;
#(
  parameter int unsigned STEAL_WAIT = 4,
  parameter int unsigned IRQ_DELAY  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              blt_req_i,
  input  logic              blt_pri_i,
  input  logic              slot_taken_i,
  input  logic              blt_start_i,
  input  logic              blt_done_i,
  input  logic              blt_zero_i,
  input  logic              legacy_busy_i,
  output logic              cpu_gnt_o,
  output logic              blt_gnt_o,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] irq_o
);
  gnt_t gnt;
  logic steal_ok, blt_active;

  cba_wait_ctr #(.STEAL_WAIT(STEAL_WAIT)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_req_i  (cpu_req_i),
    .cpu_gnt_i  (gnt.cpu),
    .steal_ok_o (steal_ok)
  );

  cba_slot_grant u_grant (
    .cpu_req_i    (cpu_req_i),
    .blt_req_i    (blt_req_i),
    .blt_active_i (blt_active),
    .blt_pri_i    (blt_pri_i),
    .slot_taken_i (slot_taken_i),
    .steal_ok_i   (steal_ok),
    .gnt_o        (gnt)
  );

  cba_blit_status #(.IRQ_DELAY(IRQ_DELAY)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (blt_start_i),
    .done_i    (blt_done_i),
    .zero_i    (blt_zero_i),
    .legacy_i  (legacy_busy_i),
    .blt_gnt_i (gnt.blt),
    .active_o  (blt_active),
    .status_o  (status_o),
    .irq_o     (irq_o)
  );

  assign cpu_gnt_o = gnt.cpu;
  assign blt_gnt_o = gnt.blt;
endmodule

// File: rtl/cba_checker.sv
module cba_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        blt_req_i,
  input logic        blt_pri_i,
  input logic        slot_taken_i,
  input logic        blt_start_i,
  input logic        blt_done_i,
  input logic        legacy_busy_i,
  input logic        cpu_gnt_o,
  input logic        blt_gnt_o,
  input logic [15:0] status_o,
  input logic [15:0] irq_o
);
  assert_gnt_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_gnt_o, blt_gnt_o}));

  assert_taken_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_taken_i |-> !(cpu_gnt_o || blt_gnt_o));

  assert_pri_no_steal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blt_pri_i && blt_req_i && !legacy_busy_i && status_o[14]) |-> !cpu_gnt_o);

  assert_blt_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blt_gnt_o |-> blt_req_i);

  assert_done_clears_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blt_done_i && !blt_start_i && !legacy_busy_i && status_o[14]) |=> !status_o[14]);

  assert_irq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[6] |=> !irq_o[6]);

  assert_start_clears_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blt_start_i |=> !status_o[13]);
endmodule

bind cpu_blit_arbiter cba_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .blt_req_i     (blt_req_i),
  .blt_pri_i     (blt_pri_i),
  .slot_taken_i  (slot_taken_i),
  .blt_start_i   (blt_start_i),
  .blt_done_i    (blt_done_i),
  .legacy_busy_i (legacy_busy_i),
  .cpu_gnt_o     (cpu_gnt_o),
  .blt_gnt_o     (blt_gnt_o),
  .status_o      (status_o),
  .irq_o         (irq_o)
);

// File: tb/cpu_blit_arbiter_bench.sv
module cpu_blit_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, blt_req = 0, blt_pri = 0, taken = 0;
  logic st = 0, dn = 0, zin = 0, leg = 0;
  logic cpu_gnt, blt_gnt;
  logic [15:0] status, irq;

  always #2 clk = ~clk;

  cpu_blit_arbiter u_cpu_blit_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .blt_req_i(blt_req),
    .blt_pri_i(blt_pri), .slot_taken_i(taken), .blt_start_i(st),
    .blt_done_i(dn), .blt_zero_i(zin), .legacy_busy_i(leg),
    .cpu_gnt_o(cpu_gnt), .blt_gnt_o(blt_gnt), .status_o(status), .irq_o(irq)
  );

  typedef struct {
    string       tag;
    bit          cg;
    bit          bg;
    logic [15:0] st;
    logic [15:0] irq;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state, from the requirements
  int m_cnt = 0;
  bit m_pend = 0, m_done = 1, m_zero = 0, m_got = 0;
  bit [3:0] m_pipe = '0;

  task automatic step(input string tag, input bit c, input bit b, input bit p,
                      input bit t, input bit s, input bit d, input bit z, input bit l);
    exp_t e;
    int eff;
    bit active, want, cgx, bgx, evt;
    @(posedge clk);
    #1;
    cpu_req = c; blt_req = b; blt_pri = p; taken = t;
    st = s; dn = d; zin = z; leg = l;
    active = !m_done;
    want   = b && active;
    eff    = m_pend ? m_cnt : 1;
    cgx    = !t && c && (!want || (!p && eff >= 4));
    bgx    = !t && want && !cgx;
    e.tag = tag; e.cg = cgx; e.bg = bgx;
    e.st = 16'h0;
    e.st[14] = !m_done && (!l || m_got);
    e.st[13] = m_zero;
    e.irq = 16'h0;
    e.irq[6] = m_pipe[3];
    q.push_back(e);
    evt = d && !m_done && !s;
    m_pipe = {m_pipe[2:0], evt};
    if (!c || cgx) begin m_cnt = 0; m_pend = 0; end
    else begin m_pend = 1; m_cnt = (eff + 1 > 15) ? 15 : eff + 1; end
    if (s) begin m_done = 0; m_zero = 0; m_got = 0; end
    else begin
      if (evt) begin m_done = 1; m_zero = z; end
      if (bgx) m_got = 1;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (cpu_gnt !== e.cg || blt_gnt !== e.bg || status !== e.st || irq !== e.irq) begin
          errors++;
          $display("FAIL %s: got cg=%b bg=%b st=%h irq=%h exp cg=%b bg=%b st=%h irq=%h",
                   e.tag, cpu_gnt, blt_gnt, status, irq, e.cg, e.bg, e.st, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset state, idle
    repeat (2) step("R8_reset", 0,0,0,0,0,0,0,0);
    // R5 blitter request while idle is refused
    step("R5_idle", 0,1,0,0,0,0,0,0);
    // R11 start clears flags
    step("R11_start", 0,1,0,0,1,0,0,0);
    step("R5_grant", 0,1,0,0,0,0,0,0);
    // R2 R7 continuous CPU against blitter, priority off
    for (int i = 0; i < 12; i++) step("R2_R7_steal", 1,1,0,0,0,0,0,0);
    step("R6_drop", 0,1,0,0,0,0,0,0);
    // R3 taken slots count toward the wait
    for (int i = 0; i < 3; i++) step("R3_taken", 1,1,0,1,0,0,0,0);
    step("R3_first_free", 1,1,0,0,0,0,0,0);
    step("R1_taken_both", 1,1,0,1,0,0,0,0);
    step("R5_after", 0,1,0,0,0,0,0,0);
    // R6 blitter idle in slot: CPU granted at once
    step("R6_direct", 1,0,0,0,0,0,0,0);
    step("R6_gap", 0,1,0,0,0,0,0,0);
    // R4 priority on: no steal
    for (int i = 0; i < 8; i++) step("R4_pri", 1,1,1,0,0,0,0,0);
    // R10 done with zero result, CPU then gets slots
    step("R10_done", 1,1,1,0,0,1,1,0);
    for (int i = 0; i < 6; i++) step("R10_irq", 1,1,1,0,0,0,0,0);
    step("R8_zero", 0,0,0,0,0,0,0,0);
    // R11 start wins over done
    step("R11_start_done", 0,0,0,0,1,1,0,0);
    step("R11_cleared", 0,0,0,0,0,0,0,0);
    step("R10_done_nz", 0,0,0,0,0,1,0,0);
    for (int i = 0; i < 5; i++) step("R10_irq_nz", 0,0,0,0,0,0,0,0);
    // R9 legacy busy
    step("R9_start", 0,0,0,0,1,0,0,1);
    for (int i = 0; i < 2; i++) step("R9_nogrant", 0,0,0,0,0,0,0,1);
    step("R9_taken", 0,1,0,1,0,0,0,1);
    step("R9_first", 0,1,0,0,0,0,0,1);
    step("R9_busy", 0,0,0,0,0,0,0,1);
    step("R9_nonlegacy", 0,0,0,0,0,0,0,0);
    step("R10_done_leg", 0,0,0,0,0,1,1,1);
    for (int i = 0; i < 5; i++) step("R10_tail", 0,0,0,0,0,0,0,0);
    // R2 request starting mid-stream, fresh blit
    step("R2_start", 0,1,0,0,1,0,0,0);
    for (int i = 0; i < 5; i++) step("R2_fresh", 1,1,0,0,0,0,0,0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule